// File: doc/BRIEF.md
# Serial-Bus Calibration Code Slave

A two-wire serial-bus slave that owns a 7-bit calibration code and presents it continuously on a parallel output bus, for example to set a reference level through a DAC. Alongside the live code it keeps a nonvolatile copy. The copy is modelled as a register that keeps its value across reset, plus a programming timer that stands in for the write time of a real memory cell.

A bus master addresses the slave and moves exactly one byte. A read returns the live code. A write carries seven code bits followed by a target selector in the last bit position. The selector sends the code either to the live register or to the nonvolatile copy. While the nonvolatile copy is being programmed, the slave refuses write transfers by not acknowledging them. Every reset reloads the live code from the nonvolatile copy.

Top module: `i2c_cal_slave`

## Requirements
- R1: One cycle after reset is released, `code_o` equals the nonvolatile copy. That copy holds 7'h40 until it is first programmed, and it is not cleared by reset.
- R2: When the 7 address bits match `DEV_ADDR`, the slave pulls SDA low (`sda_oe`=1) during the ninth clock of the address byte. It starts driving only after an SCL falling edge.
- R3: After a non-matching address, the slave never drives SDA and ignores all traffic until the next START.
- R4: A read (R/W bit = 1) returns the live code MSB first in the first 7 data bits, followed by an eighth bit of 0. The master's acknowledge is ignored.
- R5: A write data byte is sent as code bits 6..0 and then the selector. When the selector is 1, the slave acknowledges the byte and `code_o` takes the 7 code bits. The live and nonvolatile targets are never written in the same transfer.
- R6: When the selector is 0, the slave acknowledges the byte and writes the 7 code bits into the nonvolatile copy only. `code_o` does not change. The new value appears on `code_o` after the next reset.
- R7: For `PROG_CYCLES` clock cycles after a nonvolatile write, the slave does not acknowledge a write address and no further programming occurs. Read addresses are still acknowledged. Once the interval ends, writes are acknowledged again.
- R8: Only the first data byte of a write is acknowledged and applied. Later bytes in the same transfer are not acknowledged and have no effect on `code_o`.
- R9: A START returns the slave to address reception from any state, and a STOP returns it to idle. In both cases SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line, asynchronous |
| sda_i | input | 1 | Serial data line as seen on the bus, asynchronous |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| code_o | output | CODE_W | Live calibration code |

## Verification
The assertions assume that SCL and SDA are each held steady for many system clocks, so that every edge passes cleanly through the two-flop synchronisers. They also assume that SDA changes only while SCL is low, except at START and STOP. The stimulus holds each bus phase for ten clocks, moves data only in the SCL low phase, and releases SDA whenever the slave is due to drive. Under these conditions, every rise of `sda_oe` follows a detected SCL fall, and a code change can only be caused by a live write or the post-reset reload.

// File: rtl/cal_pkg.sv
package cal_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADR,
      ST_AACK,
      ST_WDAT,
      ST_DACK,
      ST_RDAT,
      ST_SKIP
   } bus_st_t;

   localparam int ADR_BITS = 8;
endpackage

// File: rtl/cal_sync.sv
module cal_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("cal_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '1;
      else        chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/cal_cond_det.sv
module cal_cond_det #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic scl_s, scl_p, sda_p;

   cal_sync #(.STAGES(STAGES)) u_scl (.clk(clk), .rst_n(rst_n), .d_i(scl_i), .q_o(scl_s));
   cal_sync #(.STAGES(STAGES)) u_sda (.clk(clk), .rst_n(rst_n), .d_i(sda_i), .q_o(sda_s));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_p <= 1'b1;
         sda_p <= 1'b1;
      end else begin
         scl_p <= scl_s;
         sda_p <= sda_s;
      end
   end

   assign scl_rise  = scl_s & ~scl_p;
   assign scl_fall  = ~scl_s & scl_p;
   assign start_det = scl_s & scl_p & sda_p & ~sda_s;
   assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/cal_bus_fsm.sv
module cal_bus_fsm
   import cal_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'h4C,
   parameter int         CODE_W   = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sda_s,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic              busy,
   input  logic [CODE_W-1:0] live_code,
   output logic              sda_oe,
   output logic              wr_live,
   output logic              wr_nv,
   output logic [CODE_W-1:0] wr_data
);
   localparam int DBITS = CODE_W + 1;
   localparam int SH_W  = (DBITS > ADR_BITS) ? DBITS : ADR_BITS;
   localparam int CNT_W = $clog2(SH_W + 1);

   generate
      if (CODE_W < 2 || CODE_W > 15) begin : g_bad
         $error("cal_bus_fsm: CODE_W out of range");
      end
   endgenerate

   bus_st_t           st_q;
   logic [SH_W-1:0]   sh_q;
   logic [DBITS-1:0]  tx_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              rw_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         sh_q    <= '0;
         tx_q    <= '0;
         cnt_q   <= '0;
         rw_q    <= 1'b0;
         sda_oe  <= 1'b0;
         wr_live <= 1'b0;
         wr_nv   <= 1'b0;
         wr_data <= '0;
      end else begin
         wr_live <= 1'b0;
         wr_nv   <= 1'b0;
         if (start_det) begin
            st_q   <= ST_ADR;
            cnt_q  <= '0;
            sda_oe <= 1'b0;
         end else if (stop_det) begin
            st_q   <= ST_IDLE;
            sda_oe <= 1'b0;
         end else begin
            unique case (st_q)
               ST_ADR: begin
                  if (scl_rise) begin
                     sh_q  <= {sh_q[SH_W-2:0], sda_s};
                     cnt_q <= cnt_q + 1'b1;
                  end else if (scl_fall && cnt_q == CNT_W'(ADR_BITS)) begin
                     if (sh_q[7:1] == DEV_ADDR && (sh_q[0] || !busy)) begin
                        st_q   <= ST_AACK;
                        rw_q   <= sh_q[0];
                        sda_oe <= 1'b1;
                     end else begin
                        st_q <= ST_SKIP;
                     end
                  end
               end
               ST_AACK: begin
                  if (scl_fall) begin
                     cnt_q <= '0;
                     if (rw_q) begin
                        tx_q   <= {live_code, 1'b0};
                        sda_oe <= ~live_code[CODE_W-1];
                        st_q   <= ST_RDAT;
                     end else begin
                        sda_oe <= 1'b0;
                        st_q   <= ST_WDAT;
                     end
                  end
               end
               ST_RDAT: begin
                  if (scl_rise) begin
                     cnt_q <= cnt_q + 1'b1;
                  end else if (scl_fall) begin
                     if (cnt_q == CNT_W'(DBITS)) begin
                        sda_oe <= 1'b0;
                        st_q   <= ST_SKIP;
                     end else begin
                        tx_q   <= {tx_q[DBITS-2:0], 1'b0};
                        sda_oe <= ~tx_q[DBITS-2];
                     end
                  end
               end
               ST_WDAT: begin
                  if (scl_rise) begin
                     sh_q  <= {sh_q[SH_W-2:0], sda_s};
                     cnt_q <= cnt_q + 1'b1;
                  end else if (scl_fall && cnt_q == CNT_W'(DBITS)) begin
                     sda_oe  <= 1'b1;
                     wr_data <= sh_q[DBITS-1:1];
                     wr_live <= sh_q[0];
                     wr_nv   <= ~sh_q[0];
                     st_q    <= ST_DACK;
                  end
               end
               ST_DACK: begin
                  if (scl_fall) begin
                     sda_oe <= 1'b0;
                     st_q   <= ST_SKIP;
                  end
               end
               default: begin
                  sda_oe <= 1'b0;
               end
            endcase
         end
      end
   end
endmodule

// File: rtl/cal_store.sv
module cal_store #(
   parameter int                CODE_W      = 7,
   parameter logic [CODE_W-1:0] NV_DEFAULT  = 7'h40,
   parameter int                PROG_CYCLES = 100000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_live,
   input  logic              wr_nv,
   input  logic [CODE_W-1:0] wr_data,
   output logic [CODE_W-1:0] code_o,
   output logic              busy_o,
   output logic              boot_o
);
   generate
      if (PROG_CYCLES < 0) begin : g_bad
         $error("cal_store: PROG_CYCLES must not be negative");
      end
   endgenerate

   // Nonvolatile copy: power-up value only, survives rst_n.
   logic [CODE_W-1:0] nv_q = NV_DEFAULT;
   logic              boot_q;

   always_ff @(posedge clk) begin
      if (wr_nv) nv_q <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_o <= '0;
         boot_q <= 1'b1;
      end else if (boot_q) begin
         code_o <= nv_q;
         boot_q <= 1'b0;
      end else if (wr_live) begin
         code_o <= wr_data;
      end
   end

   assign boot_o = boot_q;

   generate
      if (PROG_CYCLES == 0) begin : g_no_timer
         assign busy_o = 1'b0;
      end else begin : g_timer
         localparam int TW = $clog2(PROG_CYCLES + 1);
         logic [TW-1:0] tmr_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)             tmr_q <= '0;
            else if (wr_nv)         tmr_q <= TW'(PROG_CYCLES);
            else if (tmr_q != '0)   tmr_q <= tmr_q - 1'b1;
         end
         assign busy_o = (tmr_q != '0);
      end
   endgenerate
endmodule

// File: rtl/i2c_cal_slave.sv
module i2c_cal_slave #(
   parameter logic [6:0]        DEV_ADDR    = 7'h4C,
   parameter int                CODE_W      = 7,
   parameter logic [CODE_W-1:0] NV_DEFAULT  = 7'h40,
   parameter int                PROG_CYCLES = 100000,
   parameter int                SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe,
   output logic [CODE_W-1:0] code_o
);
   logic sda_s, scl_rise, scl_fall, start_det, stop_det;
   logic busy, boot, wr_live, wr_nv;
   logic [CODE_W-1:0] wr_data;

   cal_cond_det #(.STAGES(SYNC_STAGES)) u_det (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det)
   );

   cal_bus_fsm #(.DEV_ADDR(DEV_ADDR), .CODE_W(CODE_W)) u_fsm (
      .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
      .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
      .busy(busy), .live_code(code_o), .sda_oe(sda_oe),
      .wr_live(wr_live), .wr_nv(wr_nv), .wr_data(wr_data)
   );

   cal_store #(.CODE_W(CODE_W), .NV_DEFAULT(NV_DEFAULT), .PROG_CYCLES(PROG_CYCLES)) u_store (
      .clk(clk), .rst_n(rst_n), .wr_live(wr_live), .wr_nv(wr_nv),
      .wr_data(wr_data), .code_o(code_o), .busy_o(busy), .boot_o(boot)
   );
endmodule

// File: rtl/cal_checker.sv
module cal_checker #(
   parameter int CODE_W      = 7,
   parameter int PROG_CYCLES = 100000
) (
   input logic              clk,
   input logic              rst_n,
   input logic              scl_fall,
   input logic              sda_oe,
   input logic [CODE_W-1:0] code_o,
   input logic              busy,
   input logic              boot,
   input logic              wr_live,
   input logic              wr_nv
);
   localparam bit HAS_TIMER = (PROG_CYCLES > 0);

   AST_DRIVE_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> $past(scl_fall)); // R2

   AST_CODE_CAUSED: assert property (@(posedge clk) disable iff (!rst_n)
      (code_o != $past(code_o)) |-> ($past(wr_live) || $past(boot))); // R5

   AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_live && wr_nv)); // R5

   AST_NV_KEEPS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_nv |=> $stable(code_o)); // R6

   AST_BUSY_AFTER_PROG: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_nv && HAS_TIMER) |=> busy); // R7

   AST_NO_PROG_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !wr_nv); // R7
endmodule

bind i2c_cal_slave cal_checker #(.CODE_W(CODE_W), .PROG_CYCLES(PROG_CYCLES)) u_chk (
   .clk(clk), .rst_n(rst_n), .scl_fall(scl_fall), .sda_oe(sda_oe),
   .code_o(code_o), .busy(busy), .boot(boot), .wr_live(wr_live), .wr_nv(wr_nv)
);

// File: tb/test_i2c_cal_slave.sv
`timescale 1ns/1ps
module test_i2c_cal_slave;
   localparam logic [6:0] ADR  = 7'h4C;
   localparam int         PROG = 3000;
   localparam int         Q    = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1;
   logic sda_m = 1'b1;
   logic sda_oe;
   logic [6:0] code_o;
   wire  sda_bus = sda_m & ~sda_oe;

   int total = 0;
   int bad = 0;
   logic [6:0] exp_code = 7'h40;
   logic mon_en = 1'b0;

   always #10 clk = ~clk;

   i2c_cal_slave #(.DEV_ADDR(ADR), .PROG_CYCLES(PROG)) i_i2c_cal_slave (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
      .sda_oe(sda_oe), .code_o(code_o)
   );

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // reference model: outside transfers the code must equal the model and SDA is free
   always @(negedge clk) begin
      if (mon_en) begin
         total++;
         if (code_o !== exp_code || sda_oe !== 1'b0) begin
            bad++;
            $display("FAIL R3/R5 idle model actual=%0h/%0b expected=%0h/0",
                     code_o, sda_oe, exp_code);
         end
      end
   end

   task automatic wq(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_start();
      mon_en = 1'b0;
      sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q);
      sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(Q);
   endtask

   task automatic do_stop();
      sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(Q);
      sda_m = 1'b1; wq(Q);
   endtask

   task automatic settle();
      wq(4);
      mon_en = 1'b1;
   endtask

   task automatic send_bits(input logic [7:0] v, input int n);
      for (int i = 7; i > 7 - n; i--) begin
         sda_m = v[i]; wq(Q); scl_m = 1'b1; wq(2*Q); scl_m = 1'b0; wq(Q);
      end
   endtask

   task automatic send_byte(input logic [7:0] v, output logic ack);
      send_bits(v, 8);
      sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q);
      ack = ~sda_bus;
      wq(Q); scl_m = 1'b0; wq(Q);
   endtask

   task automatic recv_byte(output logic [7:0] v);
      for (int i = 7; i >= 0; i--) begin
         sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q);
         v[i] = sda_bus;
         wq(Q); scl_m = 1'b0; wq(Q);
      end
      sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(2*Q); scl_m = 1'b0; wq(Q);
   endtask

   task automatic do_reset();
      mon_en = 1'b0;
      rst_n = 1'b0; wq(5);
      rst_n = 1'b1; wq(3);
   endtask

   task automatic write_one(input logic [6:0] c, input logic p, input string req,
                            input logic exp_aa, input logic exp_da);
      logic a;
      do_start();
      send_byte({ADR, 1'b0}, a);
      check({req, " address ack"}, a, exp_aa);
      if (a) begin
         send_byte({c, p}, a);
         check({req, " data ack"}, a, exp_da);
      end
      do_stop();
   endtask

   task automatic read_one(input string req, input logic [6:0] c);
      logic a;
      logic [7:0] v;
      do_start();
      send_byte({ADR, 1'b1}, a);
      check({req, " read address ack"}, a, 1);
      recv_byte(v);
      check({req, " read byte"}, v, {c, 1'b0});
      do_stop();
      settle();
   endtask

   initial begin
      logic a;
      logic [7:0] v;
      wq(5);
      rst_n = 1'b1; wq(3);
      check("R1 reset code", code_o, 7'h40);
      check("R1 reset sda_oe", sda_oe, 0);
      settle();

      read_one("R4 R2", 7'h40);

      write_one(7'h15, 1'b1, "R5 R2", 1, 1);
      exp_code = 7'h15; settle();
      check("R5 live code", code_o, 7'h15);
      read_one("R4", 7'h15);

      // R3: foreign address, no acknowledge and no effect
      do_start();
      send_byte({7'h4D, 1'b0}, a);
      check("R3 foreign address ack", a, 0);
      send_byte({7'h00, 1'b1}, a);
      check("R3 foreign data ack", a, 0);
      do_stop(); settle();
      check("R3 code kept", code_o, 7'h15);

      // R6: program nonvolatile copy
      write_one(7'h2A, 1'b0, "R6", 1, 1);
      settle();
      check("R6 live code unchanged", code_o, 7'h15);

      // R7: writes locked out, reads served
      write_one(7'h01, 1'b1, "R7 busy", 0, 0);
      settle();
      check("R7 code after refused write", code_o, 7'h15);
      read_one("R7", 7'h15);
      wq(PROG);
      write_one(7'h33, 1'b1, "R7 after interval", 1, 1);
      exp_code = 7'h33; settle();

      // R1/R6: reset reloads programmed copy
      do_reset();
      check("R1 R6 reload after reset", code_o, 7'h2A);
      exp_code = 7'h2A; settle();

      // R8: second data byte
      do_start();
      send_byte({ADR, 1'b0}, a);
      check("R8 address ack", a, 1);
      send_byte({7'h11, 1'b1}, a);
      check("R8 first data ack", a, 1);
      send_byte({7'h22, 1'b1}, a);
      check("R8 second data ack", a, 0);
      do_stop();
      exp_code = 7'h11; settle();
      check("R8 code from first byte", code_o, 7'h11);

      // R9: START mid-byte restarts, STOP mid-address aborts
      do_start();
      send_bits(8'hF0, 4);
      do_start();
      send_byte({ADR, 1'b0}, a);
      check("R9 ack after restart", a, 1);
      send_byte({7'h05, 1'b1}, a);
      check("R9 data ack after restart", a, 1);
      do_stop();
      exp_code = 7'h05; settle();
      do_start();
      send_bits({ADR, 1'b0}, 3);
      do_stop(); settle();
      check("R9 idle after stop", sda_oe, 0);

      write_one(7'h7F, 1'b1, "R5 all ones", 1, 1);
      exp_code = 7'h7F; settle();
      read_one("R4 all ones", 7'h7F);

      wq(20);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule